// File: doc/BRIEF.md
# Uncore Performance Counter Unit

This block watches a shared cache interconnect and counts what happens on it. One free-running 64-bit counter counts clock cycles, and a bank of event counters, each 64 bits wide, counts single-cycle pulses from the interconnect. Each event counter has a 32-bit selection code that chooses which pulse it follows. A single control bit starts and stops every counter together.

Software reaches the unit through a plain 64-bit register port with byte addresses. Every counter can be written with any value, so a driver can seed it at half range and read the difference later. When a counter rolls over from all ones to zero, it raises a sticky flag. A flag is cleared by writing a one to its bit. Flags pass through a per-bit mask into one registered, level-sensitive interrupt line.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every counter, selection code, control bit, flag and mask bit is zero. A read of any address that is not mapped returns zero. The mapped addresses are: control 0x040, flags 0x048, mask 0x050, cycle counter 0x058, selection code k at 0x060+8k, event counter k at 0x160+8k. An address that is not a multiple of 8 is unmapped.
- R2: While control bit 0 is clear, no counter changes except through a host write.
- R3: While control bit 0 is set, the cycle counter grows by one on every clock and needs no selection code.
- R4: An event counter grows by one in each enabled cycle in which the pulse input chosen by its code is high. The codes map to pulse bits as follows: 0x04000701→0, 0x03000001→1, 0x0003e001→2, 0x00901202→3, 0x04008002→4, 0x006c0002→5, 0x03000002→6, 0x00000403→7. Several counters may share one code.
- R5: A counter whose selection code is not in the R4 list never counts.
- R6: Any 64-bit value written to a counter is stored exactly and counting continues from it. A host write beats an increment in the same cycle.
- R7: When a counter rolls over from all ones to zero, its flag is set: event counter k sets flag bit k, and the cycle counter sets flag bit 63.
- R8: Writing a one to a flag bit clears it. Writing a zero leaves it alone. If a rollover and a clear hit the same bit in the same cycle, the bit stays set.
- R9: The interrupt output is the registered OR of (flags AND mask). It appears one cycle after the flag or mask changes, and it stays high until software clears the flag or masks it.
- R10: Only bits 0..15 and bit 63 of the flag and mask registers exist. Other bits always read zero, and a write cannot set a flag.
- R11: Read data is registered. It shows the addressed value one cycle after a read strobe and holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| evt_pulse_i | input | 8 | Single-cycle event pulses, one per known code |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a hardware rollover and a software write-one-to-clear on the same flag bit. The second pair is a host preload and a counted pulse on the same counter. To provoke the first, the bench seeds a counter at all ones and issues the flag clear in the same cycle as the pulse that rolls it over. It then expects the flag to survive. To provoke the second, the bench writes a counter while its selected pulse is high and expects exactly the written value afterwards. A behavioural reference model, run every clock, judges the read data and the interrupt line throughout.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int NUM_CODES = 8;
  localparam int CODE_W    = 32;

  localparam int OFF_CTRL = 'h040;
  localparam int OFF_OVF  = 'h048;
  localparam int OFF_IEN  = 'h050;
  localparam int OFF_CYC  = 'h058;
  localparam int OFF_SEL  = 'h060;
  localparam int OFF_CNT  = 'h160;

  // one-hot pulse selection for a 32-bit event code; unknown codes give zero
  function automatic logic [NUM_CODES-1:0] code_onehot(input logic [CODE_W-1:0] code);
    logic [NUM_CODES-1:0] oh;
    oh = '0;
    case (code)
      32'h0400_0701: oh[0] = 1'b1;
      32'h0300_0001: oh[1] = 1'b1;
      32'h0003_e001: oh[2] = 1'b1;
      32'h0090_1202: oh[3] = 1'b1;
      32'h0400_8002: oh[4] = 1'b1;
      32'h006c_0002: oh[5] = 1'b1;
      32'h0300_0002: oh[6] = 1'b1;
      32'h0000_0403: oh[7] = 1'b1;
      default:       oh = '0;
    endcase
    return oh;
  endfunction

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign val_o  = cnt_q;
  assign wrap_o = inc_i & ~load_i & (&cnt_q);

  // R6: a host preload lands exactly, even against an increment
  a_r6_load_exact: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R2: without a load or an increment the count holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/perfmon_evt_match.sv
module perfmon_evt_match
  import perfmon_pkg::*;
(
  input  logic [CODE_W-1:0]    sel_i,
  input  logic [NUM_CODES-1:0] pulse_i,
  output logic                 hit_o
);

  logic [NUM_CODES-1:0] want;

  always_comb begin
    want  = code_onehot(sel_i);
    hit_o = |(want & pulse_i);
  end

  // R5: an unknown code never produces a hit
  always_comb begin
    if (want == '0) a_r5_unknown_code_silent: assert (!hit_o);
  end

endmodule

// File: rtl/perfmon_ovf_irq.sv
module perfmon_ovf_irq #(
  parameter int          W    = 64,
  parameter logic [W-1:0] MAP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_i,
  input  logic         ien_wr_i,
  input  logic [W-1:0] ien_val_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] ien_o,
  output logic         irq_o
);

  logic [W-1:0] status_q, ien_q, clr_mask, status_d;
  logic         irq_q;

  always_comb begin
    clr_mask = clr_wr_i ? clr_i : '0;
    status_d = ((status_q & ~clr_mask) | set_i) & MAP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ien_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (ien_wr_i) ien_q <= ien_val_i & MAP;
      irq_q <= |(status_q & ien_q);
    end
  end

  assign status_o = status_q;
  assign ien_o    = ien_q;
  assign irq_o    = irq_q;

  // R8: a rollover beats a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & MAP)) |=> ((status_q & $past(set_i & MAP)) == $past(set_i & MAP)));

  // R9: a fully masked unit raises no interrupt in the next cycle
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq_q);

  // R10: unimplemented bits stay zero
  a_r10_unmapped_bits_zero: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~MAP) == '0) && ((ien_q & ~MAP) == '0));

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 12,
  parameter int NUM_EVT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_CODES-1:0] evt_pulse_i,
  output logic                 irq_o
);

  localparam int IDX_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int CYC_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAP =
    {1'b1, {(DATA_W-1-NUM_EVT){1'b0}}, {NUM_EVT{1'b1}}};

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_OVF  = ADDR_W'(OFF_OVF);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(OFF_CYC);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_EVT * 8);

  // ---------------- address decode ----------------
  logic              is_ctrl, is_ovf, is_ien, is_cyc, sel_in, cnt_in, any_hit;
  logic [ADDR_W-1:0] sel_off, cnt_off;
  logic [IDX_W-1:0]  sel_idx, cnt_idx;

  always_comb begin
    is_ctrl = (addr_i == A_CTRL);
    is_ovf  = (addr_i == A_OVF);
    is_ien  = (addr_i == A_IEN);
    is_cyc  = (addr_i == A_CYC);
    sel_off = addr_i - A_SEL;
    cnt_off = addr_i - A_CNT;
    sel_in  = (addr_i >= A_SEL) && (sel_off < SPAN) && (addr_i[2:0] == 3'b000);
    cnt_in  = (addr_i >= A_CNT) && (cnt_off < SPAN) && (addr_i[2:0] == 3'b000);
    sel_idx = sel_off[IDX_W+2:3];
    cnt_idx = cnt_off[IDX_W+2:3];
    any_hit = is_ctrl | is_ovf | is_ien | is_cyc | sel_in | cnt_in;
  end

  // ---------------- control and selection registers ----------------
  logic              gen_en_q;
  logic [CODE_W-1:0] sel_q [NUM_EVT];

  always_ff @(posedge clk) begin
    if (rst) gen_en_q <= 1'b0;
    else if (wr_en_i && is_ctrl) gen_en_q <= wdata_i[0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_EVT; i++) begin
      if (rst) sel_q[i] <= '0;
      else if (wr_en_i && sel_in && (sel_idx == IDX_W'(i))) sel_q[i] <= wdata_i[CODE_W-1:0];
    end
  end

  // ---------------- cycle counter ----------------
  logic [DATA_W-1:0] cyc_val;
  logic              cyc_wrap, cyc_load;

  assign cyc_load = wr_en_i & is_cyc;

  perfmon_counter #(.W(DATA_W)) u_cyc (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cyc_load),
    .load_val_i (wdata_i),
    .inc_i      (gen_en_q),
    .val_o      (cyc_val),
    .wrap_o     (cyc_wrap)
  );

  // ---------------- event counter bank ----------------
  logic [DATA_W-1:0]  ev_val [NUM_EVT];
  logic [NUM_EVT-1:0] ev_wrap, ev_load, ev_inc;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic hit;

    perfmon_evt_match u_match (
      .sel_i   (sel_q[g]),
      .pulse_i (evt_pulse_i),
      .hit_o   (hit)
    );

    assign ev_load[g] = wr_en_i & cnt_in & (cnt_idx == IDX_W'(g));
    assign ev_inc[g]  = gen_en_q & hit;

    perfmon_counter #(.W(DATA_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .load_i     (ev_load[g]),
      .load_val_i (wdata_i),
      .inc_i      (ev_inc[g]),
      .val_o      (ev_val[g]),
      .wrap_o     (ev_wrap[g])
    );
  end

  // ---------------- flags and interrupt ----------------
  logic [DATA_W-1:0] set_vec, status, ien;
  logic              irq_int;

  always_comb begin
    set_vec = '0;
    set_vec[NUM_EVT-1:0] = ev_wrap;
    set_vec[CYC_BIT]     = cyc_wrap;
  end

  perfmon_ovf_irq #(.W(DATA_W), .MAP(MAP)) u_ovf (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_vec),
    .clr_wr_i  (wr_en_i & is_ovf),
    .clr_i     (wdata_i),
    .ien_wr_i  (wr_en_i & is_ien),
    .ien_val_i (wdata_i),
    .status_o  (status),
    .ien_o     (ien),
    .irq_o     (irq_int)
  );

  assign irq_o = irq_int;

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    if (is_ctrl)     rd_val = {{(DATA_W-1){1'b0}}, gen_en_q};
    else if (is_ovf) rd_val = status;
    else if (is_ien) rd_val = ien;
    else if (is_cyc) rd_val = cyc_val;
    else if (sel_in) rd_val = {{(DATA_W-CODE_W){1'b0}}, sel_q[sel_idx]};
    else if (cnt_in) rd_val = ev_val[cnt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R1: unmapped reads return zero
  a_r1_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !any_hit) |=> (rdata_o == '0));

  // R7: a cycle-counter rollover raises flag bit 63
  a_r7_cycle_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (gen_en_q && !cyc_load && (&cyc_val)) |=> status[CYC_BIT]);

  // R2: with the unit stopped and no write, the cycle count holds
  a_r2_cycle_stopped: assert property (@(posedge clk) disable iff (rst)
    (!gen_en_q && !cyc_load) |=> $stable(cyc_val));

  // R11: read data holds between strobes
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));

endmodule

// File: tb/perfmon_unit_tb_top.sv
`timescale 1ns/1ps
module perfmon_unit_tb_top;

  localparam int NE = 16;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAPM = 64'h8000_0000_0000_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  evt = '0;
  logic [63:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  perfmon_unit dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_pulse_i(evt), .irq_o(irq)
  );

  int    total = 0, bad = 0;
  bit    done = 0;
  string tag = "R1";

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cyc, m_ovf, m_ien, m_rdata;
  logic [63:0] m_cnt [NE];
  logic [31:0] m_sel [NE];
  logic        m_en, m_irq;

  function automatic int slot_of(logic [31:0] c);
    case (c)
      32'h04000701: return 0;
      32'h03000001: return 1;
      32'h0003e001: return 2;
      32'h00901202: return 3;
      32'h04008002: return 4;
      32'h006c0002: return 5;
      32'h03000002: return 6;
      32'h00000403: return 7;
      default:      return -1;
    endcase
  endfunction

  function automatic logic [63:0] m_read(logic [11:0] a);
    if (a == 12'h040) return {63'd0, m_en};
    if (a == 12'h048) return m_ovf;
    if (a == 12'h050) return m_ien;
    if (a == 12'h058) return m_cyc;
    for (int i = 0; i < NE; i++) begin
      if (a == 12'(12'h060 + 8*i)) return {32'd0, m_sel[i]};
      if (a == 12'(12'h160 + 8*i)) return m_cnt[i];
    end
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; m_ovf = 0; m_ien = 0; m_rdata = 0; m_en = 0; m_irq = 0;
      for (int i = 0; i < NE; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
    end else begin
      logic [63:0] setv;
      logic        irq_nx;
      setv = 0;
      if (rd_en) m_rdata = m_read(addr);
      irq_nx = |(m_ovf & m_ien);
      if (wr_en && addr == 12'h058) m_cyc = wdata;
      else if (m_en) begin
        if (m_cyc == ONES) setv[63] = 1'b1;
        m_cyc = m_cyc + 1;
      end
      for (int i = 0; i < NE; i++) begin
        int k;
        k = slot_of(m_sel[i]);
        if (wr_en && addr == 12'(12'h160 + 8*i)) m_cnt[i] = wdata;
        else if (m_en && k >= 0 && evt[k]) begin
          if (m_cnt[i] == ONES) setv[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (wr_en && addr == 12'h048) m_ovf = m_ovf & ~wdata;
      m_ovf = m_ovf | setv;
      if (wr_en && addr == 12'h050) m_ien = wdata & MAPM;
      for (int i = 0; i < NE; i++)
        if (wr_en && addr == 12'(12'h060 + 8*i)) m_sel[i] = wdata[31:0];
      if (wr_en && addr == 12'h040) m_en = wdata[0];
      m_irq = irq_nx;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (rdata !== m_rdata || irq !== m_irq) begin
        bad++;
        $display("FAIL %s model: rdata=%h exp=%h irq=%b exp=%b", tag, rdata, m_rdata, irq, m_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input bit we, input bit re, input logic [11:0] a,
                      input logic [63:0] d, input logic [7:0] p);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; evt = p;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    step(1'b1, 1'b0, a, d, 8'h00);
  endtask

  task automatic idle(input int n, input logic [7:0] p);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'h0, 64'h0, p);
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [63:0] exp,
                           input logic [63:0] msk, input string t);
    step(1'b0, 1'b1, a, 64'h0, 8'h00);
    step(1'b0, 1'b0, 12'h0, 64'h0, 8'h00);
    total++;
    if ((rdata & msk) !== (exp & msk)) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", t, a, rdata & msk, exp & msk);
    end
  endtask

  task automatic expect_irq(input logic exp, input string t);
    @(negedge clk);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, exp);
    end
  endtask

  function automatic logic [11:0] sel_a(int i); return 12'(12'h060 + 8*i); endfunction
  function automatic logic [11:0] cnt_a(int i); return 12'(12'h160 + 8*i); endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- scenario ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and unmapped reads
    tag = "R1";
    expect_rd(12'h040, 0, ONES, "R1 ctrl");
    expect_rd(12'h048, 0, ONES, "R1 flags");
    expect_rd(12'h050, 0, ONES, "R1 mask");
    expect_rd(12'h058, 0, ONES, "R1 cycle");
    expect_rd(sel_a(0), 0, ONES, "R1 sel0");
    expect_rd(cnt_a(5), 0, ONES, "R1 cnt5");
    expect_rd(12'h000, 0, ONES, "R1 unmapped low");
    expect_rd(12'h044, 0, ONES, "R1 unaligned");
    expect_rd(12'h1F8, 0, ONES, "R1 past bank");

    // R4 setup: codes for slots 0..7, duplicate, unknown, preload target
    tag = "R4";
    wr(sel_a(0), 64'h04000701); wr(sel_a(1), 64'h03000001);
    wr(sel_a(2), 64'h0003e001); wr(sel_a(3), 64'h00901202);
    wr(sel_a(4), 64'h04008002); wr(sel_a(5), 64'h006c0002);
    wr(sel_a(6), 64'h03000002); wr(sel_a(7), 64'h00000403);
    wr(sel_a(8), 64'h04000701); wr(sel_a(9), 64'hDEADBEEF);
    wr(sel_a(10), 64'h04000701);
    expect_rd(sel_a(9), 64'hDEADBEEF, ONES, "R4 select readback");

    // R2: stopped unit ignores pulses
    tag = "R2";
    idle(6, 8'hFF);
    expect_rd(cnt_a(0), 0, ONES, "R2 event stopped");
    expect_rd(12'h058, 0, ONES, "R2 cycle stopped");

    // R3: cycle counter with 10 enabled edges from a seed of 100
    tag = "R3";
    wr(12'h058, 64'd100);
    wr(12'h040, 64'd1);
    idle(9, 8'h00);
    wr(12'h040, 64'd0);
    expect_rd(12'h058, 64'd110, ONES, "R3 cycle count");

    // R4: mixed pulse patterns while enabled
    tag = "R4";
    wr(12'h040, 64'd1);
    for (int c = 0; c < 40; c++) idle(1, 8'((c * 37) ^ (c >> 1)));
    idle(1, 8'h00);
    for (int i = 0; i < 11; i++) begin
      step(1'b0, 1'b1, cnt_a(i), 64'h0, 8'h00);
    end
    // duplicates see identical counts
    expect_rd(cnt_a(8), m_cnt[0], ONES, "R4 shared code");

    // R5: unknown code stays at zero
    tag = "R5";
    idle(5, 8'hFF);
    expect_rd(cnt_a(9), 0, ONES, "R5 unknown code");

    // R6: exact preload and write-beats-increment
    tag = "R6";
    wr(12'h040, 64'd0);
    wr(cnt_a(10), 64'h7FFF_FFFF_FFFF_FFFF);
    expect_rd(cnt_a(10), 64'h7FFF_FFFF_FFFF_FFFF, ONES, "R6 preload");
    wr(12'h040, 64'd1);
    step(1'b1, 1'b0, cnt_a(10), 64'h1234, 8'h01);
    idle(3, 8'h00);
    expect_rd(cnt_a(10), 64'h1234, ONES, "R6 write beats increment");
    idle(2, 8'h01);

    // R7: rollovers on cycle counter and event counter 4
    tag = "R7";
    wr(12'h058, ONES - 64'd2);
    idle(4, 8'h00);
    expect_rd(12'h048, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R7 cycle flag");
    wr(cnt_a(4), ONES);
    idle(1, 8'h10);
    expect_rd(12'h048, 64'h10, 64'h10, "R7 event flag");
    expect_rd(cnt_a(4), 0, ONES, "R7 wrapped to zero");

    // R9: interrupt follows flags and mask
    tag = "R9";
    wr(12'h050, 64'h8000_0000_0000_0000);
    idle(3, 8'h00);
    expect_irq(1'b1, "R9 masked-in flag");
    wr(12'h050, 64'h0);
    idle(2, 8'h00);
    expect_irq(1'b0, "R9 masked out");
    wr(12'h050, 64'h10);
    idle(2, 8'h00);
    expect_irq(1'b1, "R9 event flag");
    wr(12'h048, 64'h10);
    idle(2, 8'h00);
    expect_irq(1'b0, "R9 cleared");

    // R8: clear colliding with a rollover on counter 7
    tag = "R8";
    wr(12'h048, ONES);
    wr(cnt_a(7), ONES);
    idle(1, 8'h80);
    wr(cnt_a(7), ONES);
    step(1'b1, 1'b0, 12'h048, 64'h80, 8'h80);
    idle(1, 8'h00);
    expect_rd(12'h048, 64'h80, 64'h80, "R8 set wins");
    wr(12'h048, 64'h0);
    expect_rd(12'h048, 64'h80, 64'h80, "R8 zero write keeps");
    wr(12'h048, 64'h80);
    expect_rd(12'h048, 64'h0, ONES, "R8 one clears");

    // R10: only mapped bits exist
    tag = "R10";
    wr(12'h050, ONES);
    expect_rd(12'h050, MAPM, ONES, "R10 mask bits");
    wr(12'h050, 64'h0);
    wr(12'h048, 64'h0);
    expect_rd(12'h048, 64'h0, ONES, "R10 no software set");

    // R11: read data holds between strobes
    tag = "R11";
    expect_rd(sel_a(3), 64'h00901202, ONES, "R11 read");
    idle(3, 8'hFF);
    total++;
    if (rdata !== 64'h00901202) begin
      bad++;
      $display("FAIL R11 hold actual=%h expected=%h", rdata, 64'h00901202);
    end

    idle(2, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule